// File: doc/BRIEF.md
# Two-Way Set-Associative Line Cache with Full-Line Bypass

This block sits between a processor-side memory port and a slow external memory that is only reachable in whole 32-byte lines. Small accesses of 1, 2 or 4 bytes are served from a two-way set-associative array of 20 sets. A hit finishes in a single cycle, while a miss costs one or two trips to the backing memory. Both read misses and write misses allocate the line. The array is write-back, so a dirty victim is copied out to memory before its replacement is fetched.

Requests that cover exactly one full line are treated as bulk traffic, such as block DMA or instruction fills. They go straight to the backing memory and never allocate. The cache keeps such traffic coherent with its own copy. A full-line write updates a cached copy if one exists. A full-line read of a dirty cached line first writes that line back.

The set count is not a power of two. The line address is therefore split by division: the set is the remainder by 20 and the tag is the quotient. The requester holds `cpu_req` and all request fields steady until it has seen `cpu_done` for one cycle. It then drops `cpu_req` for at least one cycle. The memory side holds `mem_req` and its fields steady until `mem_ack` pulses for one cycle. For a read, `mem_rdata` is valid during that pulse.

Top module: `line_cache`

## Requirements
- R1: A read of size code 0, 1 or 2 (1, 2 or 4 bytes, naturally aligned) returns the bytes at byte offset `cpu_addr[4:0]` of the line, little-endian, in the low bits of `cpu_rdata`. The upper bits are zero. A small write changes only its own bytes.
- R2: An access of size code 0, 1 or 2 that hits raises `cpu_done` on the first clock edge after the request is sampled, and it causes no memory transaction.
- R3: A small read miss to a set with a free or clean victim issues exactly one memory line read. It then installs the line, so the next small access to that line hits.
- R4: A small write miss fetches the line, merges the write and marks the line dirty. No memory write happens until that line is evicted or flushed.
- R5: The line address is `cpu_addr[31:5]`. The set is that value modulo 20 and the tag is that value divided by 20. Two lines with equal set hold both ways at once, and a third line with the same set evicts one of them.
- R6: When both ways of a set are valid, the victim is the way least recently touched by a small access. Full-line requests do not change this order.
- R7: A dirty victim is written to memory, at its own line address and with its current contents, before the fill read of the new line is issued.
- R8: A full-line read (size code 3) of a line that is not dirty in the cache issues exactly one memory read, returns all 32 bytes and allocates nothing.
- R9: A full-line write issues exactly one memory write of `cpu_wdata`. If the line is cached, its copy takes the new data and becomes clean. If it is not cached, nothing is allocated.
- R10: After reset, `cpu_done` and `mem_req` are low and every line is invalid, so the first small access to any line misses.
- R11: A full-line read of a dirty cached line writes that line back first, then reads it from memory. The line stays cached and becomes clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Request present; held until `cpu_done` is seen |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = full 32-byte line (bypass) |
| cpu_addr | input | 32 | Byte address, naturally aligned to the size |
| cpu_wdata | input | 256 | Write data; small writes use the low bytes |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 256 | Read result, valid with `cpu_done` |
| mem_req | output | 1 | Backing memory transaction pending |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_line | output | 27 | Line address of the transaction |
| mem_wdata | output | 256 | Line data for a write |
| mem_ack | input | 1 | One-cycle completion from the backing memory |
| mem_rdata | input | 256 | Line data, valid with `mem_ack` on reads |

## Verification
The directed patterns each target one distinction. Repeated small accesses inside one line separate hit timing from miss timing. Three and four lines sharing set 5 check that the victim follows access order and that only dirty victims cost a write-back. Full-line reads and writes are aimed at uncached lines, clean cached lines and dirty cached lines, which shows whether a bypass allocates, refreshes or flushes. A long random mix over 80 lines, 4 of which share each set, with a last line at the top of the address space, compares every returned value and the exact sequence of memory transactions against a behavioural model of set contents, recency and dirtiness.

// File: rtl/line_cache.sv
module line_cache #(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 32,
  parameter int SETS       = 20
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cpu_req,
  input  logic                      cpu_we,
  input  logic [1:0]                cpu_size,
  input  logic [ADDR_W-1:0]         cpu_addr,
  input  logic [LINE_BYTES*8-1:0]   cpu_wdata,
  output logic                      cpu_done,
  output logic [LINE_BYTES*8-1:0]   cpu_rdata,
  output logic                      mem_req,
  output logic                      mem_we,
  output logic [ADDR_W-$clog2(LINE_BYTES)-1:0] mem_line,
  output logic [LINE_BYTES*8-1:0]   mem_wdata,
  input  logic                      mem_ack,
  input  logic [LINE_BYTES*8-1:0]   mem_rdata
);
  localparam int LINE_BITS = LINE_BYTES * 8;
  localparam int OFF_W     = $clog2(LINE_BYTES);
  localparam int LA_W      = ADDR_W - OFF_W;
  localparam int SET_W     = $clog2(SETS);
  localparam int TAG_W     = LA_W - SET_W + 1;

  typedef enum logic [2:0] {S_IDLE, S_WB, S_FILL, S_BRD, S_BWR} state_t;

  state_t                 state;
  logic                   way_q;
  logic                   done_q;
  logic [LINE_BITS-1:0]   rdata_q;
  logic [SETS-1:0][1:0]   valid_q;
  logic [SETS-1:0][1:0]   dirty_q;
  logic [SETS-1:0]        lru_q;
  logic [TAG_W-1:0]       tag_q  [SETS][2];
  logic [LINE_BITS-1:0]   data_q [SETS][2];

  wire [LA_W-1:0]  la    = cpu_addr[ADDR_W-1:OFF_W];
  wire [SET_W-1:0] set_i = SET_W'(la % LA_W'(SETS));
  wire [TAG_W-1:0] tag_i = TAG_W'(la / LA_W'(SETS));
  wire [OFF_W+2:0] sh    = {cpu_addr[OFF_W-1:0], 3'b000};
  wire             is_line = (cpu_size == 2'd3);

  wire hit0 = valid_q[set_i][0] && (tag_q[set_i][0] == tag_i);
  wire hit1 = valid_q[set_i][1] && (tag_q[set_i][1] == tag_i);
  wire hit  = hit0 | hit1;
  wire hway = hit1;
  wire vway = !valid_q[set_i][0] ? 1'b0 :
              !valid_q[set_i][1] ? 1'b1 : lru_q[set_i];

  wire accept    = (state == S_IDLE) && cpu_req && !done_q;
  wire hit_acc   = accept && !is_line && hit;
  wire fill_done = (state == S_FILL) && mem_ack;
  wire bwr_upd   = (state == S_BWR) && mem_ack && hit;

  logic [LINE_BYTES-1:0] ben;
  logic [LINE_BITS-1:0]  bmask, rmask;
  always_comb begin
    case (cpu_size)
      2'd0:    begin ben = LINE_BYTES'(4'h1); rmask = LINE_BITS'(8'hFF); end
      2'd1:    begin ben = LINE_BYTES'(4'h3); rmask = LINE_BITS'(16'hFFFF); end
      2'd2:    begin ben = LINE_BYTES'(4'hF); rmask = LINE_BITS'(32'hFFFF_FFFF); end
      default: begin ben = '1;                rmask = '1; end
    endcase
    ben = ben << cpu_addr[OFF_W-1:0];
    for (int i = 0; i < LINE_BYTES; i++) bmask[i*8 +: 8] = {8{ben[i]}};
  end

  wire [LINE_BITS-1:0] wshift      = cpu_wdata << sh;
  wire [LINE_BITS-1:0] hit_line    = data_q[set_i][hway];
  wire [LINE_BITS-1:0] merged_hit  = (hit_line & ~bmask) | (wshift & bmask);
  wire [LINE_BITS-1:0] merged_fill = (mem_rdata & ~bmask) | (wshift & bmask);
  wire [LINE_BITS-1:0] rd_hit      = (hit_line >> sh) & rmask;
  wire [LINE_BITS-1:0] rd_fill     = (mem_rdata >> sh) & rmask;
  wire [LA_W-1:0]      victim_la   = LA_W'(tag_q[set_i][way_q]) * LA_W'(SETS) + LA_W'(set_i);

  assign mem_req   = (state != S_IDLE);
  assign mem_we    = (state == S_WB) || (state == S_BWR);
  assign mem_line  = (state == S_WB) ? victim_la : la;
  assign mem_wdata = (state == S_WB) ? data_q[set_i][way_q] : cpu_wdata;
  assign cpu_done  = done_q;
  assign cpu_rdata = rdata_q;

  always_ff @(posedge clk) begin
    if (hit_acc && cpu_we) data_q[set_i][hway] <= merged_hit;
    if (fill_done) begin
      data_q[set_i][way_q] <= cpu_we ? merged_fill : mem_rdata;
      tag_q[set_i][way_q]  <= tag_i;
    end
    if (bwr_upd) data_q[set_i][hway] <= cpu_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      way_q   <= 1'b0;
      done_q  <= 1'b0;
      rdata_q <= '0;
      valid_q <= '0;
      dirty_q <= '0;
      lru_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (is_line) begin
            way_q <= hway;
            if (cpu_we)                          state <= S_BWR;
            else if (hit && dirty_q[set_i][hway]) state <= S_WB;
            else                                 state <= S_BRD;
          end else if (hit) begin
            lru_q[set_i] <= ~hway;
            if (cpu_we) dirty_q[set_i][hway] <= 1'b1;
            else        rdata_q <= rd_hit;
            done_q <= 1'b1;
          end else begin
            way_q <= vway;
            state <= (valid_q[set_i][vway] && dirty_q[set_i][vway]) ? S_WB : S_FILL;
          end
        end
        S_WB: if (mem_ack) begin
          if (is_line) begin
            dirty_q[set_i][way_q] <= 1'b0;
            state <= S_BRD;
          end else begin
            state <= S_FILL;
          end
        end
        S_FILL: if (mem_ack) begin
          valid_q[set_i][way_q] <= 1'b1;
          dirty_q[set_i][way_q] <= cpu_we;
          lru_q[set_i]          <= ~way_q;
          if (!cpu_we) rdata_q <= rd_fill;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        S_BRD: if (mem_ack) begin
          rdata_q <= mem_rdata;
          done_q  <= 1'b1;
          state   <= S_IDLE;
        end
        S_BWR: if (mem_ack) begin
          if (hit) dirty_q[set_i][hway] <= 1'b0;
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);
  a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_line) && $stable(mem_we)));
  a_r7_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && mem_ack && !is_line) |=> (state == S_FILL && mem_req && !mem_we));
  a_r11_flush_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WB && mem_ack && is_line) |=> (state == S_BRD && mem_req && !mem_we));
  a_r8_bypass_no_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_BRD && mem_ack) |=> $stable(valid_q));
  a_r3_fill_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FILL && mem_ack) |=> (cpu_done && !mem_req));
endmodule

// File: tb/line_cache_test.sv
module line_cache_test;
  localparam int LAT = 3;
  localparam logic [31:0] WR = 32'h8000_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_we = 0;
  logic [1:0] cpu_size = 0;
  logic [31:0] cpu_addr = 0;
  logic [255:0] cpu_wdata = 0;
  logic cpu_done, mem_req, mem_we;
  logic [255:0] cpu_rdata, mem_wdata;
  logic [26:0] mem_line;
  logic mem_ack = 0;
  logic [255:0] mem_rdata = 0;

  always #5 clk = ~clk;

  line_cache uut (.clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_size(cpu_size), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_line(mem_line), .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  int n_checks = 0, n_fail = 0;
  bit finished = 0, in_hit = 0;
  int mem_cnt = 0;
  logic [31:0] obs_ops[$];
  logic [31:0] exp_ops[$];
  logic [255:0] mem_a [logic [26:0]];
  logic [7:0]   refm  [logic [31:0]];
  int cq [20][$];
  bit dirt [int];

  function automatic logic [7:0] init_byte(logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[15:8] ^ a[31:24] ^ 8'h5A;
  endfunction
  function automatic logic [7:0] refb(logic [31:0] a);
    return refm.exists(a) ? refm[a] : init_byte(a);
  endfunction
  function automatic logic [255:0] mem_get(logic [26:0] l);
    logic [255:0] v;
    if (mem_a.exists(l)) return mem_a[l];
    for (int i = 0; i < 32; i++) v[i*8 +: 8] = init_byte({l, 5'b0} + 32'(i));
    return v;
  endfunction

  task automatic check(bit ok, string req, string what, logic [255:0] act, logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (in_hit) begin
      n_checks++;
      if (mem_req) begin
        n_fail++;
        $display("FAIL R2 memory traffic during hit: actual 1 expected 0");
      end
    end
    if (mem_ack) mem_ack = 0;
    else if (mem_req) begin
      mem_cnt++;
      if (mem_cnt >= LAT) begin
        mem_cnt = 0;
        mem_ack = 1;
        if (mem_we) begin
          mem_a[mem_line] = mem_wdata;
          obs_ops.push_back(WR | 32'(mem_line));
        end else begin
          mem_rdata = mem_get(mem_line);
          obs_ops.push_back(32'(mem_line));
        end
      end
    end
  end

  function automatic int find(int s, int la);
    for (int i = 0; i < cq[s].size(); i++) if (cq[s][i] == la) return i;
    return -1;
  endfunction

  task automatic do_op(bit we, int sz, logic [31:0] addr, logic [255:0] wd, string req);
    int la, s, idx, nb, cyc;
    bit hit;
    logic [255:0] exp_rd;
    logic [31:0] base;
    la = int'(addr >> 5);
    s = la % 20;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 32;
    base = (sz == 3) ? {addr[31:5], 5'b0} : addr;
    exp_ops.delete();
    hit = 0;
    idx = find(s, la);
    if (sz == 3) begin
      if (we) begin
        exp_ops.push_back(WR | 32'(la));
        if (idx >= 0) dirt[la] = 0;
      end else begin
        if (idx >= 0 && dirt[la]) begin
          exp_ops.push_back(WR | 32'(la));
          dirt[la] = 0;
        end
        exp_ops.push_back(32'(la));
      end
    end else begin
      if (idx >= 0) begin
        hit = 1;
        cq[s].delete(idx);
      end else begin
        if (cq[s].size() == 2) begin
          if (dirt[cq[s][1]]) exp_ops.push_back(WR | 32'(cq[s][1]));
          void'(cq[s].pop_back());
        end
        exp_ops.push_back(32'(la));
        dirt[la] = 0;
      end
      cq[s].push_front(la);
      if (we) dirt[la] = 1;
    end
    exp_rd = '0;
    for (int i = 0; i < nb; i++) begin
      if (we) refm[base + 32'(i)] = wd[i*8 +: 8];
      exp_rd[i*8 +: 8] = refb(base + 32'(i));
    end
    @(negedge clk);
    obs_ops.delete();
    cpu_we = we; cpu_size = 2'(sz); cpu_addr = addr; cpu_wdata = wd; cpu_req = 1;
    in_hit = hit;
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while (!cpu_done && cyc < 300);
    cpu_req = 0;
    in_hit = 0;
    if (hit) check(cyc == 1, "R2", "hit latency", 256'(cyc), 256'd1);
    else     check(cpu_done, req, "completion", 256'(cpu_done), 256'd1);
    check(obs_ops.size() == exp_ops.size(), req, "memory transaction count",
          256'(obs_ops.size()), 256'(exp_ops.size()));
    for (int i = 0; i < obs_ops.size() && i < exp_ops.size(); i++)
      check(obs_ops[i] == exp_ops[i], req, "memory transaction (bit31=write)",
            256'(obs_ops[i]), 256'(exp_ops[i]));
    if (!we) check(cpu_rdata == exp_rd, req, "read data", cpu_rdata, exp_rd);
  endtask

  function automatic logic [255:0] pat(int k);
    logic [255:0] v;
    for (int i = 0; i < 8; i++) v[i*32 +: 32] = 32'(k) * 32'h9E37_79B1 + 32'(i);
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired: actual hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(cpu_done == 0, "R10", "done after reset", 256'(cpu_done), 256'd0);
    check(mem_req == 0, "R10", "mem_req after reset", 256'(mem_req), 256'd0);
    do_op(0, 0, 32'(5*32+3), '0, "R10");          // first access misses
    do_op(0, 1, 32'(5*32+6), '0, "R1");           // hit, half
    do_op(0, 2, 32'(5*32+28), '0, "R1");          // hit, word at top of line
    do_op(1, 2, 32'(5*32+8), pat(1), "R1");       // hit write, upper garbage ignored
    do_op(0, 2, 32'(5*32+8), '0, "R1");
    do_op(0, 0, 32'(5*32+12), '0, "R1");          // neighbour byte untouched
    do_op(1, 0, 32'(100*32+1), pat(2), "R4");     // write miss, no write-back
    do_op(0, 1, 32'(100*32+0), '0, "R4");
    do_op(0, 2, 32'(25*32), '0, "R3");            // set 5 second way
    do_op(0, 0, 32'(5*32), '0, "R5");             // touch 5, 25 becomes LRU
    do_op(0, 2, 32'(45*32), '0, "R6");            // evicts clean 25
    do_op(0, 2, 32'(5*32+4), '0, "R6");           // 5 still cached
    do_op(0, 2, 32'(65*32), '0, "R7");            // evicts 45 (clean)
    do_op(0, 2, 32'(85*32), '0, "R7");            // evicts dirty 5: write-back then fill
    do_op(0, 2, 32'(5*32+8), '0, "R7");           // written data came back
    do_op(0, 3, 32'(300*32), '0, "R8");           // bypass read miss
    do_op(0, 0, 32'(300*32+9), '0, "R8");         // not allocated: misses
    do_op(1, 3, 32'(300*32), pat(3), "R9");       // bypass write updates cached copy
    do_op(0, 2, 32'(300*32+16), '0, "R9");        // hit with new data
    do_op(1, 1, 32'(45*32+2), pat(4), "R11");
    do_op(0, 3, 32'(45*32), '0, "R11");           // flush then read
    do_op(0, 1, 32'(45*32+2), '0, "R11");         // still cached, clean
    do_op(1, 3, 32'(777*32), pat(5), "R9");       // uncached bypass write
    do_op(0, 2, 32'(777*32+4), '0, "R9");
    do_op(1, 2, 32'hFFFF_FFFC, pat(6), "R5");     // top line of address space
    do_op(0, 2, 32'hFFFF_FFFC, '0, "R5");
    for (int n = 0; n < 600; n++) begin
      int sz, la, nb;
      logic [31:0] off;
      sz = int'($urandom_range(0, 4)); if (sz == 4) sz = 2;
      if ($urandom_range(0, 9) == 0) sz = 3;
      la = int'($urandom_range(0, 79));
      nb = (sz == 0) ? 1 : (sz == 1) ? 2 : (sz == 2) ? 4 : 32;
      off = 32'($urandom_range(0, 31)) & ~32'(nb - 1);
      do_op(1'($urandom_range(0, 1)), sz, 32'(la*32) + off, pat(n + 10), "R1");
    end
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule